// File: doc/BRIEF.md
# Register Bus Window Splitter

This block fans one upstream register request out to a set of downstream register subspaces. Each subspace owns a contiguous address window, fixed at elaboration by a base and a size. A window claims an address when base <= address < base + size; the address one past its top is outside it. Every downstream port sees the request address with its own base subtracted, so a subspace decodes only offsets inside its window. Every port also sees the unchanged write data. The read and write strobes reach a port only while the address lies inside that port's window.

On the way back, the responses of all subspaces fold into one upstream response. Read data words are ORed bit by bit and data-valid flags are ORed. Ready flags are ANDed, so any subspace can hold the upstream ready low. A subspace with nothing to report drives zero data, valid low and ready high, and so leaves the merged response untouched. Both paths are purely combinational, so the splitter adds no cycle of latency.

Handshake rules: read and write strobes are single-cycle pulses. Data-valid is a single-cycle pulse that qualifies the read data. Ready is the back-pressure signal: it must be valid one clock after a write strobe, and while it is low the master holds off and keeps the address stable. The master keeps the address stable in every cycle where it samples data, valid or ready.

Top module: `reg_window_split`

## Requirements
- R1: At most one downstream port carries a read or write strobe at any time, and a port strobes only when base <= address < base + size for its window.
- R2: The address equal to base + size is not claimed by that window. It reaches the window above it when that window starts there.
- R3: Downstream port i always receives the upstream address minus base i, modulo 2^16, whether or not the address hits.
- R4: Every downstream port receives the 32-bit upstream write data unchanged, hit or miss.
- R5: Inside its window, a port's read strobe equals the upstream read strobe and its write strobe equals the upstream write strobe. Outside the window, both are low.
- R6: The upstream read data is the bitwise OR of all downstream read data words.
- R7: The upstream data-valid is high exactly when at least one downstream data-valid is high.
- R8: The upstream ready is high only when every downstream ready is high. A single subspace holding ready low stalls it.
- R9: A subspace that is idle (zero data, valid low, ready high) does not change the merged response. With every subspace idle, the upstream sees zero data, valid low and ready high.
- R10: Request and response paths have no register: a change on an input is visible on the outputs within the same clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| up_addr | input | ADDR_W | Upstream request address |
| up_wdata | input | DATA_W | Upstream write data |
| up_rd | input | 1 | Upstream read strobe (one-cycle pulse) |
| up_wr | input | 1 | Upstream write strobe (one-cycle pulse) |
| up_rdata | output | DATA_W | Merged read data |
| up_rvalid | output | 1 | Merged data-valid |
| up_ready | output | 1 | Merged ready (back-pressure) |
| dn_addr | output | NUM_WIN*ADDR_W | Rebased address per window, window i at bits [i*ADDR_W +: ADDR_W] |
| dn_wdata | output | NUM_WIN*DATA_W | Write data per window, window i at [i*DATA_W +: DATA_W] |
| dn_rd | output | NUM_WIN | Gated read strobe per window, bit i = window i |
| dn_wr | output | NUM_WIN | Gated write strobe per window, bit i = window i |
| dn_rdata | input | NUM_WIN*DATA_W | Read data from each subspace, window i at [i*DATA_W +: DATA_W] |
| dn_rvalid | input | NUM_WIN | Data-valid from each subspace |
| dn_ready | input | NUM_WIN | Ready from each subspace |

## Verification
The bench sweeps every address from zero past the top of the highest window, plus the far end of the space, with reads and then with writes. In that sweep it computes each window's hit and rebased offset arithmetically. A comparison written with <= on the top bound would show up as two windows strobing at a shared boundary. A window whose rebased address drops the subtraction, or wraps wrongly below its base, would show a wrong offset. The response side is swept over every combination of per-subspace valid and ready. A merge that ORs ready, or ANDs valid, would let a stalled subspace's ready go unseen or hide a lone valid pulse. A merge that selects rather than ORs data would drop bits from the other subspaces.

// File: rtl/rws_pkg.sv
package rws_pkg;

  localparam int ADDR_W_DEF = 16;
  localparam int DATA_W_DEF = 32;

  // Half-open window test: base <= addr < base + size, done in 33 bits so a
  // window touching the top of the space does not wrap.
  function automatic logic win_hit(input logic [31:0] addr,
                                   input int          base,
                                   input int          size);
    logic [32:0] a;
    logic [32:0] lo;
    logic [32:0] hi;
    a  = {1'b0, addr};
    lo = 33'(base);
    hi = 33'(base) + 33'(size);
    return (a >= lo) && (a < hi);
  endfunction

  // True when two non-empty windows share at least one address.
  function automatic logic win_overlap(input int b0, input int s0,
                                       input int b1, input int s1);
    return (s0 > 0) && (s1 > 0) && (b0 < b1 + s1) && (b1 < b0 + s0);
  endfunction

endpackage

// File: rtl/rws_window_port.sv
module rws_window_port
  import rws_pkg::*;
#(
  parameter int ADDR_W = ADDR_W_DEF,
  parameter int DATA_W = DATA_W_DEF,
  parameter int BASE   = 0,
  parameter int SIZE   = 4
) (
  input  logic [ADDR_W-1:0] up_addr,
  input  logic [DATA_W-1:0] up_wdata,
  input  logic              up_rd,
  input  logic              up_wr,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [DATA_W-1:0] dn_wdata,
  output logic              dn_rd,
  output logic              dn_wr
);

  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);

  logic hit;

  always_comb begin
    hit      = win_hit(32'(up_addr), BASE, SIZE);
    // offset inside the window; wraps modulo 2^ADDR_W when below base
    dn_addr  = up_addr - BASE_A;
    dn_wdata = up_wdata;
    dn_rd    = up_rd & hit;
    dn_wr    = up_wr & hit;
  end

endmodule

// File: rtl/rws_resp_merge.sv
module rws_resp_merge #(
  parameter int NUM_WIN = 3,
  parameter int DATA_W  = 32
) (
  input  logic [NUM_WIN*DATA_W-1:0] dn_rdata,
  input  logic [NUM_WIN-1:0]        dn_rvalid,
  input  logic [NUM_WIN-1:0]        dn_ready,
  output logic [DATA_W-1:0]         up_rdata,
  output logic                      up_rvalid,
  output logic                      up_ready
);

  logic [DATA_W-1:0] acc;

  always_comb begin
    acc = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      acc = acc | dn_rdata[i*DATA_W +: DATA_W];
    end
    up_rdata  = acc;
    up_rvalid = |dn_rvalid;
    up_ready  = &dn_ready;
  end

endmodule

// File: rtl/reg_window_split.sv
module reg_window_split
  import rws_pkg::*;
#(
  parameter int NUM_WIN            = 3,
  parameter int ADDR_W             = ADDR_W_DEF,
  parameter int DATA_W             = DATA_W_DEF,
  parameter int WIN_BASE [NUM_WIN] = '{32'h0000, 32'h0004, 32'h0100},
  parameter int WIN_SIZE [NUM_WIN] = '{32'h0004, 32'h0010, 32'h0040}
) (
  input  logic [ADDR_W-1:0]         up_addr,
  input  logic [DATA_W-1:0]         up_wdata,
  input  logic                      up_rd,
  input  logic                      up_wr,
  output logic [DATA_W-1:0]         up_rdata,
  output logic                      up_rvalid,
  output logic                      up_ready,
  output logic [NUM_WIN*ADDR_W-1:0] dn_addr,
  output logic [NUM_WIN*DATA_W-1:0] dn_wdata,
  output logic [NUM_WIN-1:0]        dn_rd,
  output logic [NUM_WIN-1:0]        dn_wr,
  input  logic [NUM_WIN*DATA_W-1:0] dn_rdata,
  input  logic [NUM_WIN-1:0]        dn_rvalid,
  input  logic [NUM_WIN-1:0]        dn_ready
);

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    rws_window_port #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .BASE   (WIN_BASE[g]),
      .SIZE   (WIN_SIZE[g])
    ) u_port (
      .up_addr  (up_addr),
      .up_wdata (up_wdata),
      .up_rd    (up_rd),
      .up_wr    (up_wr),
      .dn_addr  (dn_addr[g*ADDR_W +: ADDR_W]),
      .dn_wdata (dn_wdata[g*DATA_W +: DATA_W]),
      .dn_rd    (dn_rd[g]),
      .dn_wr    (dn_wr[g])
    );
  end

  rws_resp_merge #(
    .NUM_WIN (NUM_WIN),
    .DATA_W  (DATA_W)
  ) u_merge (
    .dn_rdata  (dn_rdata),
    .dn_rvalid (dn_rvalid),
    .dn_ready  (dn_ready),
    .up_rdata  (up_rdata),
    .up_rvalid (up_rvalid),
    .up_ready  (up_ready)
  );

endmodule

// File: rtl/rws_checker.sv
module rws_checker
  import rws_pkg::*;
#(
  parameter int NUM_WIN            = 3,
  parameter int ADDR_W             = ADDR_W_DEF,
  parameter int DATA_W             = DATA_W_DEF,
  parameter int WIN_BASE [NUM_WIN] = '{32'h0000, 32'h0004, 32'h0100},
  parameter int WIN_SIZE [NUM_WIN] = '{32'h0004, 32'h0010, 32'h0040}
) (
  input logic [ADDR_W-1:0]         up_addr,
  input logic [DATA_W-1:0]         up_wdata,
  input logic                      up_rd,
  input logic                      up_wr,
  input logic [DATA_W-1:0]         up_rdata,
  input logic                      up_rvalid,
  input logic                      up_ready,
  input logic [NUM_WIN*ADDR_W-1:0] dn_addr,
  input logic [NUM_WIN*DATA_W-1:0] dn_wdata,
  input logic [NUM_WIN-1:0]        dn_rd,
  input logic [NUM_WIN-1:0]        dn_wr,
  input logic [NUM_WIN*DATA_W-1:0] dn_rdata,
  input logic [NUM_WIN-1:0]        dn_rvalid,
  input logic [NUM_WIN-1:0]        dn_ready
);

  // Configuration: windows must not overlap (R1)
  initial begin
    for (int i = 0; i < NUM_WIN; i++) begin
      for (int j = i + 1; j < NUM_WIN; j++) begin
        // R1
        overlap_cfg_chk: assert (!win_overlap(WIN_BASE[i], WIN_SIZE[i],
                                              WIN_BASE[j], WIN_SIZE[j]))
          else $error("windows %0d and %0d overlap", i, j);
      end
    end
  end

  always_comb begin
    // R1
    one_strobe_chk: assert ($onehot0(dn_rd | dn_wr));
    // R5
    rd_follow_chk: assert ((dn_rd & ~{NUM_WIN{up_rd}}) == '0);
    // R5
    wr_follow_chk: assert ((dn_wr & ~{NUM_WIN{up_wr}}) == '0);
    // R7
    valid_merge_chk: assert (up_rvalid == (dn_rvalid != '0));
    // R8
    ready_stall_chk: assert (up_ready == (dn_ready == '1));
    for (int i = 0; i < NUM_WIN; i++) begin
      // R3
      rebase_chk: assert (ADDR_W'(dn_addr[i*ADDR_W +: ADDR_W] + ADDR_W'(WIN_BASE[i])) == up_addr);
      // R4
      wdata_pass_chk: assert (dn_wdata[i*DATA_W +: DATA_W] == up_wdata);
      // R6
      data_cover_chk: assert ((up_rdata & dn_rdata[i*DATA_W +: DATA_W]) == dn_rdata[i*DATA_W +: DATA_W]);
      // R1
      strobe_range_chk: assert (!(dn_rd[i] | dn_wr[i]) ||
                                win_hit(32'(up_addr), WIN_BASE[i], WIN_SIZE[i]));
    end
  end

endmodule

bind reg_window_split rws_checker #(
  .NUM_WIN  (NUM_WIN),
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .WIN_BASE (WIN_BASE),
  .WIN_SIZE (WIN_SIZE)
) u_rws_chk (
  .up_addr   (up_addr),
  .up_wdata  (up_wdata),
  .up_rd     (up_rd),
  .up_wr     (up_wr),
  .up_rdata  (up_rdata),
  .up_rvalid (up_rvalid),
  .up_ready  (up_ready),
  .dn_addr   (dn_addr),
  .dn_wdata  (dn_wdata),
  .dn_rd     (dn_rd),
  .dn_wr     (dn_wr),
  .dn_rdata  (dn_rdata),
  .dn_rvalid (dn_rvalid),
  .dn_ready  (dn_ready)
);

// File: tb/tb_reg_window_split.sv
module tb_reg_window_split;

  localparam int CLK_P = 10;
  localparam int NW    = 3;
  localparam int AW    = 16;
  localparam int DW    = 32;
  localparam int BASES [NW] = '{32'h0000, 32'h0004, 32'h0100};
  localparam int SIZES [NW] = '{32'h0004, 32'h0010, 32'h0040};

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic [AW-1:0]    up_addr;
  logic [DW-1:0]    up_wdata;
  logic             up_rd;
  logic             up_wr;
  logic [DW-1:0]    up_rdata;
  logic             up_rvalid;
  logic             up_ready;
  logic [NW*AW-1:0] dn_addr;
  logic [NW*DW-1:0] dn_wdata;
  logic [NW-1:0]    dn_rd;
  logic [NW-1:0]    dn_wr;
  logic [NW*DW-1:0] dn_rdata;
  logic [NW-1:0]    dn_rvalid;
  logic [NW-1:0]    dn_ready;

  reg_window_split #(
    .NUM_WIN (NW), .ADDR_W (AW), .DATA_W (DW),
    .WIN_BASE (BASES), .WIN_SIZE (SIZES)
  ) dut (
    .up_addr (up_addr), .up_wdata (up_wdata), .up_rd (up_rd), .up_wr (up_wr),
    .up_rdata (up_rdata), .up_rvalid (up_rvalid), .up_ready (up_ready),
    .dn_addr (dn_addr), .dn_wdata (dn_wdata), .dn_rd (dn_rd), .dn_wr (dn_wr),
    .dn_rdata (dn_rdata), .dn_rvalid (dn_rvalid), .dn_ready (dn_ready)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h (addr %h)", req, act, exp, up_addr);
    end
  endtask

  function automatic logic [31:0] pat(input int i);
    return (32'h1 << i) | (32'h100 << (2 * i)) | 32'h8000_0000;
  endfunction

  // Drive one request between edges and check every port in the same half cycle.
  task automatic req(input int addr, input logic rd, input logic wr);
    int nstb;
    @(negedge clk);
    up_addr  = addr[15:0];
    up_wdata = {~addr[15:0], addr[15:0]};
    up_rd    = rd;
    up_wr    = wr;
    #(CLK_P/4);
    nstb = 0;
    for (int i = 0; i < NW; i++) begin
      logic hit;
      logic [AW-1:0] ea;
      hit = (addr >= BASES[i]) && (addr < BASES[i] + SIZES[i]);
      ea  = AW'(addr - BASES[i]);
      chk("R3 rebased addr", 32'(dn_addr[i*AW +: AW]), 32'(ea));
      chk("R4 wdata", dn_wdata[i*DW +: DW], {~addr[15:0], addr[15:0]});
      chk("R5 rd strobe", 32'(dn_rd[i]), 32'(hit & rd));
      chk("R5 wr strobe", 32'(dn_wr[i]), 32'(hit & wr));
      nstb += int'(dn_rd[i] | dn_wr[i]);
    end
    chk("R1 strobe count", 32'(nstb), (nstb > 1) ? 32'd1 : 32'(nstb));
  endtask

  task automatic resp(input logic [NW-1:0] vm, input logic [NW-1:0] rm);
    logic [DW-1:0] exp_d;
    @(negedge clk);
    exp_d = '0;
    for (int i = 0; i < NW; i++) begin
      dn_rdata[i*DW +: DW] = vm[i] ? pat(i) : '0;
      if (vm[i]) exp_d = exp_d | pat(i);
    end
    dn_rvalid = vm;
    dn_ready  = rm;
    #(CLK_P/4);
    chk("R6 merged data", up_rdata, exp_d);
    chk("R7 merged valid", 32'(up_rvalid), 32'(vm != 0));
    chk("R8 merged ready", 32'(up_ready), 32'(rm == 3'b111));
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    up_addr   = '0;
    up_wdata  = '0;
    up_rd     = 1'b0;
    up_wr     = 1'b0;
    dn_rdata  = '0;
    dn_rvalid = '0;
    dn_ready  = '1;
    repeat (2) @(posedge clk);

    // R9: everything idle at start
    #(CLK_P/4);
    chk("R9 idle data", up_rdata, 32'h0);
    chk("R9 idle valid", 32'(up_rvalid), 32'd0);
    chk("R9 idle ready", 32'(up_ready), 32'd1);
    chk("R5 idle strobes", 32'({dn_rd, dn_wr}), 32'd0);

    // R1 R3 R4 R5: sweep reads, then writes, over and beyond all windows
    for (int a = 0; a < 32'h180; a++) req(a, 1'b1, 1'b0);
    for (int a = 0; a < 32'h180; a++) req(a, 1'b0, 1'b1);
    req(32'hFFFF, 1'b1, 1'b0);
    req(32'h8000, 1'b0, 1'b1);
    req(32'h0010, 1'b0, 1'b0);

    // R2: lowest, highest and one past the top of every window
    for (int i = 0; i < NW; i++) begin
      req(BASES[i], 1'b1, 1'b0);
      chk("R2 lowest claimed", 32'(dn_rd[i]), 32'd1);
      req(BASES[i] + SIZES[i] - 1, 1'b1, 1'b0);
      chk("R2 highest claimed", 32'(dn_rd[i]), 32'd1);
      req(BASES[i] + SIZES[i], 1'b0, 1'b1);
      chk("R2 top+1 not claimed", 32'(dn_wr[i]), 32'd0);
    end
    // R2: window 0 top+1 is window 1 base
    req(BASES[0] + SIZES[0], 1'b1, 1'b0);
    chk("R2 handoff to next window", 32'(dn_rd), 32'b010);

    // R6 R7 R8: every valid/ready combination
    for (int v = 0; v < 8; v++)
      for (int r = 0; r < 8; r++)
        resp(3'(v), 3'(r));

    // R9: a lone active subspace shows through idle neighbours unchanged
    for (int i = 0; i < NW; i++) begin
      resp(3'(1 << i), 3'b111);
      chk("R9 lone data", up_rdata, pat(i));
    end

    // R10: outputs follow inputs with no clock edge in between
    @(negedge clk);
    up_addr = 16'h0105;
    up_rd   = 1'b1;
    dn_ready = 3'b011;
    #1;
    chk("R10 same-cycle strobe", 32'(dn_rd), 32'b100);
    chk("R10 same-cycle ready", 32'(up_ready), 32'd0);
    up_rd    = 1'b0;
    dn_ready = 3'b111;

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule